// File: doc/BRIEF.md
# Display Frame Fetch Address Generator

This block produces the memory addresses from which a display DMA engine reads pixel data. Software programs a start address, an end address and a line-geometry word while video output is off. The block keeps those values in a shadow set and copies them into its working set at the next frame-start strobe from the display timing generator, so a frame in progress never sees a half-updated configuration.

Addresses are halfword addresses: a byte address shifted right by one. Each fetch reads one 32-bit word, which is two halfwords. On each line-start strobe the block issues a run of fetch requests that covers the page width. It then skips the programmed offset, so a narrow window of a wider virtual screen can be shown; an offset of zero gives contiguous lines. Fetching stops at the end address. The end address is normally the start plus the line length in bytes times the line count, halfword-converted. Requests use a valid/ready handshake toward a memory-read port.

Top module: `lcd_fetch_addr_gen`

## Requirements
- R1: After reset, req_valid is 0 and req_addr is 0.
- R2: A write with cfg_we=1 while video_en=0 updates a shadow register. cfg_sel=0 selects the start address, cfg_sel=1 the end address, and cfg_sel=2 the geometry word. In the geometry word, the page width in halfwords is bits [PW-1:0] and the offset is bits [AW-1:PW]. cfg_sel=3 writes nothing. A shadow value only reaches req_addr or the fetch pattern after the next frame_start.
- R3: Configuration writes made while video_en=1 are ignored.
- R4: On frame_start the pointer (req_addr) loads the shadow start address, any line in progress is dropped, and req_valid is 0 until a line_start is seen.
- R5: A line_start accepted while idle starts a line of floor(page_width/2) requests at the current pointer. The address advances by 2 only on a cycle where req_valid and req_ready are both 1, and it holds while the request is stalled.
- R6: After the last request of a line, req_addr equals the line's first address plus page width plus offset.
- R7: A line_start is not acted on when the pointer is at or above the end address. Within a line, requests stop as soon as the next address would reach the end address, and the pointer is left at that next address.
- R8: Geometry and end values written during a frame do not change the fetch pattern of the frame already running.
- R9: A line_start that arrives while a line is still being fetched is ignored. When frame_start and line_start arrive in the same cycle, frame_start wins and no line starts.
- R10: While video_en=0, req_valid is 0 and any line in progress is abandoned. A new line_start is needed after video_en returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| video_en | input | 1 | Video output enabled; gates fetching and locks configuration |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | AW | Configuration write data |
| frame_start | input | 1 | Frame-start strobe from the timing generator |
| line_start | input | 1 | Line-start strobe from the timing generator |
| req_ready | input | 1 | Memory port accepts the current request |
| req_valid | output | 1 | Fetch request pending |
| req_addr | output | AW | Halfword address of the fetch (also the live pointer) |

## Verification
req_addr shows the live pointer on every cycle, so a bad line base, count or offset shows up at the port no later than the cycle after the line ends. A wrong word count shows up as req_valid dropping one cycle too early or too late. A shadow register that leaks into the working set is seen as a wrong first address or a wrong line length in the frame where the write was made. Stalls, ignored strobes and the end-address cutoff are each checked in the cycle right after the triggering edge.

// File: rtl/lcd_fetch_addr_gen.sv
module lcd_fetch_addr_gen #(
  parameter int AW = 21,
  parameter int PW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          video_en,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          frame_start,
  input  logic          line_start,
  input  logic          req_ready,
  output logic          req_valid,
  output logic [AW-1:0] req_addr
);
  localparam int OW = AW - PW;
  localparam int CW = PW;

  logic [AW-1:0] s_start, s_end, a_end, ptr, base;
  logic [PW-1:0] s_pw, a_pw;
  logic [OW-1:0] s_off, a_off;
  logic [CW-1:0] cnt;
  logic          busy;

  wire [AW-1:0] pw_x       = AW'(a_pw);
  wire [AW-1:0] off_x      = AW'(a_off);
  wire [AW-1:0] step       = ptr + AW'(2);
  wire [AW-1:0] next_line  = base + pw_x + off_x;
  wire [CW-1:0] line_words = CW'(a_pw >> 1);
  wire          accept     = req_valid & req_ready;
  wire          open_line  = line_start & ~busy & (ptr < a_end);

  assign req_valid = busy & video_en;
  assign req_addr  = ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_start <= '0;
      s_end   <= '0;
      s_pw    <= '0;
      s_off   <= '0;
    end else if (cfg_we && !video_en) begin
      case (cfg_sel)
        2'd0: s_start <= cfg_wdata;
        2'd1: s_end   <= cfg_wdata;
        2'd2: begin
          s_pw  <= cfg_wdata[PW-1:0];
          s_off <= cfg_wdata[AW-1:PW];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_end <= '0;
      a_pw  <= '0;
      a_off <= '0;
    end else if (frame_start) begin
      a_end <= s_end;
      a_pw  <= s_pw;
      a_off <= s_off;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr  <= '0;
      base <= '0;
      cnt  <= '0;
      busy <= 1'b0;
    end else if (frame_start) begin
      ptr  <= s_start;
      base <= s_start;
      cnt  <= '0;
      busy <= 1'b0;
    end else if (!video_en) begin
      busy <= 1'b0;
    end else if (busy) begin
      if (accept) begin
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) begin
          ptr  <= next_line;
          busy <= 1'b0;
        end else begin
          ptr <= step;
          if (step >= a_end) busy <= 1'b0;
        end
      end
    end else if (open_line) begin
      if (line_words == '0) begin
        ptr <= ptr + pw_x + off_x;
      end else begin
        busy <= 1'b1;
        cnt  <= line_words;
        base <= ptr;
      end
    end
  end
endmodule

module lcd_fetch_addr_gen_chk #(
  parameter int AW = 21
) (
  input logic          clk,
  input logic          rst_n,
  input logic          video_en,
  input logic          frame_start,
  input logic          req_ready,
  input logic          req_valid,
  input logic [AW-1:0] req_addr,
  input logic [AW-1:0] s_start,
  input logic [AW-1:0] a_end
);
  // R10
  video_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !video_en |-> !req_valid);
  // R4
  frame_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !req_valid);
  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !frame_start) |=> (!video_en || (req_valid && $stable(req_addr))));
  // R5
  accept_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !frame_start) |=> (req_addr != $past(req_addr)));
  // R7
  below_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_addr < a_end));
  // R3
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    video_en |=> $stable(s_start));
endmodule

bind lcd_fetch_addr_gen lcd_fetch_addr_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .video_en(video_en), .frame_start(frame_start),
  .req_ready(req_ready), .req_valid(req_valid), .req_addr(req_addr),
  .s_start(s_start), .a_end(a_end)
);

// File: tb/sim_lcd_fetch_addr_gen.sv
`timescale 1ns/1ps
module sim_lcd_fetch_addr_gen;
  localparam int AW = 21;
  localparam int PW = 10;
  localparam int MASK = (1 << AW) - 1;

  logic clk = 0, rst_n = 0, video_en = 0, cfg_we = 0;
  logic [1:0] cfg_sel = 0;
  logic [AW-1:0] cfg_wdata = 0;
  logic frame_start = 0, line_start = 0, req_ready = 0;
  logic req_valid;
  logic [AW-1:0] req_addr;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  lcd_fetch_addr_gen #(.AW(AW), .PW(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .video_en(video_en), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .frame_start(frame_start),
    .line_start(line_start), .req_ready(req_ready), .req_valid(req_valid),
    .req_addr(req_addr));

  // behavioural reference
  int ms_start, ms_end, ms_pw, ms_off, ma_end, ma_pw, ma_off;
  int m_ptr, m_base, m_cnt;
  bit m_busy;

  always @(posedge clk) begin
    if (!rst_n) begin
      ms_start = 0; ms_end = 0; ms_pw = 0; ms_off = 0;
      ma_end = 0; ma_pw = 0; ma_off = 0;
      m_ptr = 0; m_base = 0; m_cnt = 0; m_busy = 0;
    end else begin
      automatic bit acc = m_busy && video_en && req_ready;
      if (frame_start) begin
        ma_end = ms_end; ma_pw = ms_pw; ma_off = ms_off;
        m_ptr = ms_start; m_base = ms_start; m_cnt = 0; m_busy = 0;
      end else if (!video_en) begin
        m_busy = 0;
      end else if (m_busy) begin
        if (acc) begin
          if (m_cnt == 1) begin
            m_ptr = (m_base + ma_pw + ma_off) & MASK;
            m_busy = 0;
          end else begin
            m_ptr = (m_ptr + 2) & MASK;
            if (m_ptr >= ma_end) m_busy = 0;
          end
          m_cnt = m_cnt - 1;
        end
      end else if (line_start && m_ptr < ma_end) begin
        if (ma_pw / 2 == 0) m_ptr = (m_ptr + ma_pw + ma_off) & MASK;
        else begin m_busy = 1; m_cnt = ma_pw / 2; m_base = m_ptr; end
      end
      if (cfg_we && !video_en) begin
        if (cfg_sel == 0) ms_start = int'(cfg_wdata);
        else if (cfg_sel == 1) ms_end = int'(cfg_wdata);
        else if (cfg_sel == 2) begin
          ms_pw = int'(cfg_wdata) % (1 << PW);
          ms_off = int'(cfg_wdata) >> PW;
        end
      end
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R5 model valid", int'(req_valid), int'(m_busy && video_en));
      chk("R5 model addr", int'(req_addr), m_ptr);
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask
  task automatic wr(input logic [1:0] s, input int d);
    cfg_we = 1; cfg_sel = s; cfg_wdata = AW'(d); tick(); cfg_we = 0;
  endtask
  task automatic fs();
    frame_start = 1; tick(); frame_start = 0;
  endtask
  task automatic ls();
    line_start = 1; tick(); line_start = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    ticks(3); rst_n = 1; tick();
    chk("R1 valid", int'(req_valid), 0);
    chk("R1 addr", int'(req_addr), 0);

    wr(0, 'h100); wr(1, 'h118); wr(2, 8);
    chk("R2 not yet", int'(req_addr), 0);
    fs();
    chk("R2 start", int'(req_addr), 'h100);
    chk("R4 idle", int'(req_valid), 0);
    video_en = 1; req_ready = 1; tick();
    chk("R4 wait line", int'(req_valid), 0);

    ls();
    chk("R5 first", int'(req_addr), 'h100);
    ticks(3);
    chk("R5 third step", int'(req_addr), 'h106);
    chk("R5 valid", int'(req_valid), 1);
    tick();
    chk("R6 line end valid", int'(req_valid), 0);
    chk("R6 line end addr", int'(req_addr), 'h108);

    req_ready = 0; ls(); ticks(2);
    chk("R5 stall addr", int'(req_addr), 'h108);
    chk("R5 stall valid", int'(req_valid), 1);
    ls();
    req_ready = 1; ticks(3);
    chk("R9 busy strobe", int'(req_addr), 'h10E);
    tick();
    chk("R9 count kept", int'(req_valid), 0);
    chk("R9 count addr", int'(req_addr), 'h110);

    ls(); ticks(4);
    chk("R6 third line", int'(req_addr), 'h118);
    ls();
    chk("R7 at end", int'(req_valid), 0);
    chk("R7 ptr kept", int'(req_addr), 'h118);

    wr(0, 'h200);
    fs();
    chk("R3 ignored", int'(req_addr), 'h100);

    video_en = 0;
    wr(0, 'h300); wr(1, 'h314); wr(2, 6 | (4 << PW)); wr(3, 'h7);
    video_en = 1;
    ls(); ticks(3);
    chk("R8 old width", int'(req_valid), 1);
    tick();
    chk("R8 old end", int'(req_addr), 'h108);
    fs();
    chk("R2 new start", int'(req_addr), 'h300);

    ls(); ticks(3);
    chk("R6 offset skip", int'(req_addr), 'h30A);
    chk("R6 offset valid", int'(req_valid), 0);
    ls(); ticks(3);
    chk("R6 second line", int'(req_addr), 'h314);
    ls();
    chk("R7 stop", int'(req_valid), 0);

    video_en = 0; wr(1, 'h303); video_en = 1;
    fs(); ls();
    chk("R7 mid first", int'(req_addr), 'h300);
    tick();
    chk("R7 mid second", int'(req_addr), 'h302);
    tick();
    chk("R7 mid cut valid", int'(req_valid), 0);
    chk("R7 mid cut addr", int'(req_addr), 'h304);

    frame_start = 1; line_start = 1; tick(); frame_start = 0; line_start = 0;
    chk("R9 frame wins valid", int'(req_valid), 0);
    chk("R9 frame wins addr", int'(req_addr), 'h300);

    ls();
    chk("R10 line up", int'(req_valid), 1);
    video_en = 0; #1;
    chk("R10 gated", int'(req_valid), 0);
    tick(); video_en = 1; tick();
    chk("R10 abandoned", int'(req_valid), 0);
    chk("R10 ptr held", int'(req_addr), 'h300);
    ls();
    chk("R10 restart", int'(req_valid), 1);
    ticks(3);
    summary();
  end
endmodule